// File: doc/BRIEF.md
# Delay-Aware Adaptive Output Port Selector

This block is the route-computation stage of a five-port mesh router. The ports are North, East, South, West and Local. For every destination node it holds one delay figure per compass direction. Each figure is the propagation cost of reaching that node through that direction, with any process-variation penalty folded in. The block also holds one queuing-delay figure per direction, and it treats that figure as the congestion level of the port. A router therefore has up to four alternative routes to each node.

When a flit header arrives, it carries a destination ID. The selector adds the delay figure and the congestion figure of each direction, with saturation. Directions whose link is down, and directions that hold the unreachable marker for that destination, are left out. The selector grants the cheapest remaining direction as a one-hot port vector. A header addressed to the router's own ID goes to the Local port. When no direction qualifies, a no-route flag is raised instead.

The table contents come from a single write port. Routing-message logic elsewhere in the router drives that port. Requests and responses both use a valid/ready handshake, and the response is registered.

Top module: `dly_route_sel`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Every propagation entry resets to the all-ones unreachable value and every queuing entry resets to 0. A header to any foreign node therefore answers with no-route until the tables are written.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Its response appears with `rsp_valid`=1 after that same edge. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields do not change. This holds even when the tables or `link_up` change during the stall.
- R4: When `req_dest` equals `my_id`, the grant is 5'b10000 (bit 4 = Local) and `rsp_noroute` is 0, whatever the tables and link states.
- R5: Grant bit i (0=N, 1=E, 2=S, 3=W) selects the eligible direction of least cost. The cost of a direction is its propagation entry for the destination plus its queuing entry.
- R6: When costs are equal, the lower direction index wins, so N beats E, E beats S, and S beats W.
- R7: A direction whose `link_up` bit is 0 when the request is taken is never granted.
- R8: A direction whose propagation entry for the destination is 12'hFFF is never granted.
- R9: If no direction is eligible for a foreign destination, `rsp_noroute` is 1 and the grant is 0.
- R10: Writes use `upd_tbl`=0 for the propagation table (indexed by `upd_dest` and `upd_port`) and `upd_tbl`=1 for the queuing table (indexed by `upd_port`). Writes with `upd_port` of 4 or more change nothing. A request taken on the same edge as a write sees the values from before the write.
- R11: A sum above 4095 saturates to 4095 and the direction stays eligible. Two saturated directions then tie under the order in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | NODE_W | ID of this router |
| link_up | input | 4 | Live flag per direction, bit0=N .. bit3=W |
| upd_valid | input | 1 | Table write strobe |
| upd_tbl | input | 1 | 0 = propagation table, 1 = queuing table |
| upd_dest | input | NODE_W | Destination row for propagation writes |
| upd_port | input | 3 | Direction written, 0..3 |
| upd_value | input | DLY_W | Value written |
| req_valid | input | 1 | Header present |
| req_ready | output | 1 | Header accepted when high with req_valid |
| req_dest | input | NODE_W | Destination ID of the header |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed when high with rsp_valid |
| rsp_grant | output | 5 | One-hot port grant, bit4 = Local |
| rsp_noroute | output | 1 | No eligible direction |

## Verification
Every result is due one clock edge after the request is taken. The bench drives each request on a falling edge, so the request is taken on the rising edge that follows. It then samples grant, no-route and valid on the next falling edge. Table writes land on the rising edge after they are driven, and the bench only issues requests after that edge. The one exception is the R10 case, which presents a write and a request together so that the response must reflect the older table contents. During a stall, the bench samples on each falling edge and compares against the response it captured first.

// File: rtl/dly_route_pkg.sv
package dly_route_pkg;
   localparam int NUM_DIRS  = 4;
   localparam int NUM_PORTS = NUM_DIRS + 1;
   localparam int LOCAL_IDX = NUM_DIRS;
   localparam int PORT_W    = 3;
   localparam logic TBL_PROP  = 1'b0;
   localparam logic TBL_QUEUE = 1'b1;
endpackage

// File: rtl/drs_tables.sv
module drs_tables
   import dly_route_pkg::*;
#(
   parameter int NODE_W = 3,
   parameter int DLY_W  = 12
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic                             wr_tbl,
   input  logic [NODE_W-1:0]                wr_dest,
   input  logic [PORT_W-1:0]                wr_port,
   input  logic [DLY_W-1:0]                 wr_val,
   input  logic [NODE_W-1:0]                rd_dest,
   output logic [NUM_DIRS-1:0][DLY_W-1:0]   prop_row,
   output logic [NUM_DIRS-1:0][DLY_W-1:0]   queue_row
);
   localparam int NUM_DEST = 1 << NODE_W;

   logic [NUM_DIRS-1:0][DLY_W-1:0] prop_q [NUM_DEST];
   logic [NUM_DIRS-1:0][DLY_W-1:0] queue_q;

   for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
      for (genvar k = 0; k < NUM_DIRS; k++) begin : g_dir
         always_ff @(posedge clk) begin
            if (!rst_n)
               prop_q[d][k] <= '1;
            else if (wr_en && wr_tbl == TBL_PROP &&
                     wr_dest == NODE_W'(d) && wr_port == PORT_W'(k))
               prop_q[d][k] <= wr_val;
         end
      end
   end

   for (genvar k = 0; k < NUM_DIRS; k++) begin : g_queue
      always_ff @(posedge clk) begin
         if (!rst_n)
            queue_q[k] <= '0;
         else if (wr_en && wr_tbl == TBL_QUEUE && wr_port == PORT_W'(k))
            queue_q[k] <= wr_val;
      end
   end

   assign prop_row  = prop_q[rd_dest];
   assign queue_row = queue_q;
endmodule

// File: rtl/drs_cost.sv
module drs_cost
   import dly_route_pkg::*;
#(
   parameter int DLY_W = 12
) (
   input  logic [NUM_DIRS-1:0][DLY_W-1:0] prop_row,
   input  logic [NUM_DIRS-1:0][DLY_W-1:0] queue_row,
   input  logic [NUM_DIRS-1:0]            link_up,
   output logic [NUM_DIRS-1:0][DLY_W-1:0] cost,
   output logic [NUM_DIRS-1:0]            eligible
);
   localparam logic [DLY_W-1:0] UNREACH = '1;

   for (genvar k = 0; k < NUM_DIRS; k++) begin : g_dir
      logic [DLY_W:0] raw_sum;
      assign raw_sum     = {1'b0, prop_row[k]} + {1'b0, queue_row[k]};
      assign cost[k]     = raw_sum[DLY_W] ? UNREACH : raw_sum[DLY_W-1:0];
      assign eligible[k] = link_up[k] && (prop_row[k] != UNREACH);
   end
endmodule

// File: rtl/drs_pick.sv
module drs_pick
   import dly_route_pkg::*;
#(
   parameter int DLY_W = 12
) (
   input  logic [NUM_DIRS-1:0][DLY_W-1:0] cost,
   input  logic [NUM_DIRS-1:0]            eligible,
   output logic [NUM_DIRS-1:0]            grant,
   output logic                           found
);
   logic [NUM_DIRS-1:0] beats;

   // a direction wins when it is eligible and no lower index is at least as
   // cheap, and no higher index is strictly cheaper
   for (genvar k = 0; k < NUM_DIRS; k++) begin : g_cmp
      always_comb begin
         beats[k] = eligible[k];
         for (int j = 0; j < NUM_DIRS; j++) begin
            if (j < k && eligible[j] && cost[j] <= cost[k]) beats[k] = 1'b0;
            if (j > k && eligible[j] && cost[j] <  cost[k]) beats[k] = 1'b0;
         end
      end
   end

   assign grant = beats;
   assign found = |eligible;
endmodule

// File: rtl/dly_route_sel.sv
module dly_route_sel
   import dly_route_pkg::*;
#(
   parameter int NODE_W = 3,
   parameter int DLY_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NODE_W-1:0] my_id,
   input  logic [3:0]        link_up,
   input  logic              upd_valid,
   input  logic              upd_tbl,
   input  logic [NODE_W-1:0] upd_dest,
   input  logic [2:0]        upd_port,
   input  logic [DLY_W-1:0]  upd_value,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [NODE_W-1:0] req_dest,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [4:0]        rsp_grant,
   output logic              rsp_noroute
);
   if (NODE_W < 1 || NODE_W > 8) begin : g_bad_node
      $error("dly_route_sel: NODE_W must be 1..8");
   end
   if (DLY_W < 2 || DLY_W > 24) begin : g_bad_dly
      $error("dly_route_sel: DLY_W must be 2..24");
   end

   logic [NUM_DIRS-1:0][DLY_W-1:0] prop_row;
   logic [NUM_DIRS-1:0][DLY_W-1:0] queue_row;
   logic [NUM_DIRS-1:0][DLY_W-1:0] cost;
   logic [NUM_DIRS-1:0]            eligible;
   logic [NUM_DIRS-1:0]            dir_grant;
   logic                           dir_found;
   logic                           accept;
   logic                           self_hit;
   logic [NUM_PORTS-1:0]           grant_d;
   logic                           noroute_d;

   drs_tables #(.NODE_W(NODE_W), .DLY_W(DLY_W)) u_tables (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (upd_valid),
      .wr_tbl   (upd_tbl),
      .wr_dest  (upd_dest),
      .wr_port  (upd_port),
      .wr_val   (upd_value),
      .rd_dest  (req_dest),
      .prop_row (prop_row),
      .queue_row(queue_row)
   );

   drs_cost #(.DLY_W(DLY_W)) u_cost (
      .prop_row (prop_row),
      .queue_row(queue_row),
      .link_up  (link_up),
      .cost     (cost),
      .eligible (eligible)
   );

   drs_pick #(.DLY_W(DLY_W)) u_pick (
      .cost    (cost),
      .eligible(eligible),
      .grant   (dir_grant),
      .found   (dir_found)
   );

   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;
   assign self_hit  = (req_dest == my_id);

   always_comb begin
      grant_d   = '0;
      noroute_d = 1'b0;
      if (self_hit) begin
         grant_d[LOCAL_IDX] = 1'b1;
      end else begin
         grant_d[NUM_DIRS-1:0] = dir_grant;
         noroute_d             = !dir_found;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_grant   <= '0;
         rsp_noroute <= 1'b0;
      end else if (accept) begin
         rsp_valid   <= 1'b1;
         rsp_grant   <= grant_d;
         rsp_noroute <= noroute_d;
      end else if (rsp_ready) begin
         rsp_valid   <= 1'b0;
      end
   end
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
   parameter int NODE_W = 3,
   parameter int DLY_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NODE_W-1:0] my_id,
   input logic [3:0]        link_up,
   input logic              req_valid,
   input logic              req_ready,
   input logic [NODE_W-1:0] req_dest,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [4:0]        rsp_grant,
   input logic              rsp_noroute
);
   logic [NODE_W-1:0] cap_dest;
   logic [3:0]        cap_link;

   always_ff @(posedge clk) begin
      if (req_valid && req_ready) begin
         cap_dest <= req_dest;
         cap_link <= link_up;
      end
   end

   assert_result_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_grant) && $stable(rsp_noroute)));

   assert_self_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && cap_dest == my_id) |-> (rsp_grant == 5'b10000 && !rsp_noroute));

   assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0(rsp_grant));

   assert_live_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && cap_dest != my_id) |-> ((rsp_grant[3:0] & ~cap_link) == 4'b0));

   assert_noroute_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_noroute) |-> (rsp_grant == 5'b0));

   assert_route_has_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_noroute) |-> ($countones(rsp_grant) == 1));
endmodule

bind dly_route_sel drs_checker #(.NODE_W(NODE_W), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/dly_route_sel_bench.sv
`timescale 1ns/1ps
module dly_route_sel_bench;
   localparam int NW = 3;
   localparam int DW = 12;
   localparam int ND = 1 << NW;
   localparam logic [NW-1:0] ME = 3'd5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NW-1:0] my_id = ME;
   logic [3:0]    link_up = 4'hF;
   logic          upd_valid = 1'b0;
   logic          upd_tbl = 1'b0;
   logic [NW-1:0] upd_dest = '0;
   logic [2:0]    upd_port = '0;
   logic [DW-1:0] upd_value = '0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [NW-1:0] req_dest = '0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b1;
   logic [4:0]    rsp_grant;
   logic          rsp_noroute;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] mp [ND][4];
   logic [DW-1:0] mq [4];

   always #4 clk = ~clk;

   dly_route_sel u_dly_route_sel (.*);

   task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // expected {valid, noroute, grant} from the requirements
   function automatic logic [6:0] model(input logic [NW-1:0] d, input logic [3:0] m);
      int best = 1 << 20;
      int pick = -1;
      logic [4:0] g = '0;
      if (d == ME) return {1'b1, 1'b0, 5'b10000};
      for (int k = 0; k < 4; k++) begin
         int s;
         s = int'(mp[d][k]) + int'(mq[k]);
         if (s > 4095) s = 4095;
         if (m[k] && mp[d][k] != 12'hFFF && s < best) begin
            best = s;
            pick = k;
         end
      end
      if (pick < 0) return {1'b1, 1'b1, 5'b0};
      g[pick] = 1'b1;
      return {1'b1, 1'b0, g};
   endfunction

   task automatic wr(input logic t, input logic [NW-1:0] d, input logic [2:0] p, input logic [DW-1:0] v);
      @(negedge clk);
      upd_valid = 1'b1; upd_tbl = t; upd_dest = d; upd_port = p; upd_value = v;
      @(negedge clk);
      upd_valid = 1'b0;
      if (p < 3'd4) begin
         if (t) mq[p] = v; else mp[d][p] = v;
      end
   endtask

   task automatic issue(input logic [NW-1:0] d, input logic [3:0] m, output logic [6:0] got);
      @(negedge clk);
      req_valid = 1'b1; req_dest = d; link_up = m; rsp_ready = 1'b1;
      @(negedge clk);
      got = {rsp_valid, rsp_noroute, rsp_grant};
      req_valid = 1'b0;
   endtask

   initial begin
      logic [6:0] got;
      logic [6:0] held;
      for (int d = 0; d < ND; d++)
         for (int k = 0; k < 4; k++) mp[d][k] = 12'hFFF;
      for (int k = 0; k < 4; k++) mq[k] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {5'b0, rsp_valid, req_ready}, {5'b0, 1'b0, 1'b1});
      issue(3'd2, 4'hF, got);
      chk("R1 fresh tables give no-route", got, {1'b1, 1'b1, 5'b0});
      issue(ME, 4'h0, got);
      chk("R4 own id selects Local", got, 7'b1010000);

      // R10: writes with port 4..7 are dropped
      wr(1'b0, 3'd1, 3'd4, 12'd1);
      wr(1'b0, 3'd1, 3'd7, 12'd1);
      issue(3'd1, 4'hF, got);
      chk("R10 out-of-range port ignored", got, {1'b1, 1'b1, 5'b0});

      // fill tables arithmetically, some entries unreachable (R8)
      for (int d = 0; d < ND; d++)
         for (int k = 0; k < 4; k++)
            wr(1'b0, 3'(d), 3'(k), ((d + k) % 5 == 0) ? 12'hFFF : 12'((d * 37 + k * 53) % 41 * 60));

      // sweep all link masks and destinations (R5, R7, R8, R9, R4)
      for (int m = 0; m < 16; m++) begin
         for (int k = 0; k < 4; k++) wr(1'b1, 3'd0, 3'(k), 12'((m * 29 + k * 311) % 900));
         for (int d = 0; d < ND; d++) begin
            issue(3'(d), 4'(m), got);
            chk($sformatf("R5/R7/R8/R9 sweep dest=%0d mask=%0h", d, m), got, model(3'(d), 4'(m)));
         end
      end

      // R6 ties
      for (int k = 0; k < 4; k++) begin
         wr(1'b0, 3'd2, 3'(k), 12'd100);
         wr(1'b1, 3'd0, 3'(k), 12'd50);
      end
      issue(3'd2, 4'hF, got);
      chk("R6 tie goes to N", got, 7'b1000001);
      issue(3'd2, 4'hE, got);
      chk("R6 tie goes to E without N", got, 7'b1000010);
      issue(3'd2, 4'h8, got);
      chk("R7 only W live", got, 7'b1001000);

      // R11 saturation
      wr(1'b0, 3'd3, 3'd0, 12'd4000); wr(1'b1, 3'd0, 3'd0, 12'd200);
      wr(1'b0, 3'd3, 3'd1, 12'd3000); wr(1'b1, 3'd0, 3'd1, 12'd1094);
      wr(1'b0, 3'd3, 3'd2, 12'hFFF);  wr(1'b0, 3'd3, 3'd3, 12'hFFF);
      issue(3'd3, 4'hF, got);
      chk("R11 saturated N loses to 4094 E", got, 7'b1000010);
      wr(1'b1, 3'd0, 3'd1, 12'd2000);
      issue(3'd3, 4'hF, got);
      chk("R11 two saturated costs tie to N", got, 7'b1000001);
      issue(3'd3, 4'h2, got);
      chk("R11 saturated cost stays eligible", got, 7'b1000010);
      issue(3'd3, 4'hC, got);
      chk("R9 only unreachable directions live", got, 7'b1100000);

      // R10 same-edge write sees old value
      @(negedge clk);
      req_valid = 1'b1; req_dest = 3'd3; link_up = 4'hF;
      upd_valid = 1'b1; upd_tbl = 1'b0; upd_dest = 3'd3; upd_port = 3'd2; upd_value = 12'd1;
      @(negedge clk);
      got = {rsp_valid, rsp_noroute, rsp_grant};
      req_valid = 1'b0; upd_valid = 1'b0;
      chk("R10 request beside write sees old table", got, 7'b1000001);
      mp[3][2] = 12'd1;
      issue(3'd3, 4'hF, got);
      chk("R10 write visible afterwards", got, 7'b1000100);

      // R2/R3 stall
      @(negedge clk);
      req_valid = 1'b1; req_dest = 3'd3; link_up = 4'hF; rsp_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      held = {rsp_valid, rsp_noroute, rsp_grant};
      chk("R2 response after accept", held, 7'b1000100);
      chk("R2 ready low while stalled", {6'b0, req_ready}, 7'b0);
      link_up = 4'h0;
      wr(1'b0, 3'd3, 3'd2, 12'hFFF);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R3 response held during stall", {rsp_valid, rsp_noroute, rsp_grant}, held);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk("R2 valid drops after consume", {6'b0, rsp_valid}, 7'b0);
      chk("R2 ready back high", {6'b0, req_ready}, 7'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule